// File: doc/BRIEF.md
# I/O Address Translation Table Walker

This block turns an I/O virtual address (IOVA) into a system physical address. It walks a radix page table in memory that has from one to six levels. A request supplies the IOVA, the physical address of the root table, the number of levels, and the device and domain identifiers that tag any fault. At each level the walker forms the address of an 8-byte entry and issues a single read on a request/response memory port. Only one read is in flight at a time. It then decodes the returned entry and either descends a level, finishes with a translation, or stops with a fault.

A finished translation gives the physical page base, the page-size shift and the read/write permissions. The permissions are the AND of every entry visited on the way down. A leaf can use the default 4 KiB page. It can also mark a variable page size: the next-level code is 7 and the size is written as a run of ones in the address field starting at bit 12. A fault gives a type code, a present flag, an address and the two identifiers.

The state machine has six states:
- IDLE accepts a request. It goes to ISSUE_READ, or to FAULT when the root level is invalid.
- ISSUE_READ drives the read for one cycle and goes to WAIT_DATA.
- WAIT_DATA waits for the response. It goes to FAULT on an error and to DECODE otherwise.
- DECODE goes back to ISSUE_READ to descend, to DONE on a leaf, or to FAULT.
- DONE and FAULT each pulse `done` for one cycle and return to IDLE.

Top module: `io_pt_walker`

## Requirements
- R1: After reset `done` and `mem_req_valid` are 0 and `req_ready` is 1.
- R2: At current level L, the read address is the table base plus 8 times the index ((IOVA >> shift(L)) & 0x1FF). At most one read is outstanding.
- R3: shift(L) = 12 + 9*(L-1), which gives 12, 21, 30, 39, 48 and 57 for levels 1 to 6.
- R4: A read response with `mem_rsp_err`=1 ends the walk with `flt_code`=1 (target abort). In that case `flt_present`=0, `flt_addr` is the failing entry address, and the device and domain IDs are reported.
- R5: The entry layout is: bit 0 present, bits 11:9 next level, bits 51:12 address field, bit 61 read, bit 62 write. An entry with next level 0 is a 4 KiB leaf: `res_spa` is its address field and `res_shift` is 12.
- R6: For next level 7, `res_shift` is one more than the position of the first zero bit at or above bit 12 of the entry. `res_spa` is the entry's address field.
- R7: A next-level-7 size is accepted only when shift(L) < `res_shift` < shift(L+1). Otherwise the walk faults with `flt_code`=3, `flt_present`=1 and `flt_addr` = IOVA.
- R8: An entry with bit 0 clear faults with `flt_code`=2, `flt_present`=0 and `flt_addr` = IOVA.
- R9: The walk faults with `flt_code`=4, `flt_present`=1 and `flt_addr` = IOVA in two cases. The first is a root level of 0 or above 6; no read is issued. The second is an intermediate entry whose next level is not below the current level.
- R10: `res_perm` = {write, read} is the AND of the permission bits of every entry visited, including the leaf.
- R11: `done` lasts exactly one cycle per accepted request. `req_ready` is 1 only in IDLE. A request presented while the walker is busy is ignored.
- R12: A next-level-7 entry read at level 6 always faults with `flt_code`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Start a walk |
| req_ready | output | 1 | Walker idle, able to accept a request |
| req_iova | input | IOVA_W | Address to translate |
| req_root | input | PA_W | Root table address (bits 11:0 ignored) |
| req_levels | input | 3 | Number of table levels |
| req_dev_id | input | ID_W | Device ID for fault reports |
| req_dom_id | input | ID_W | Domain ID for fault reports |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_addr | output | PA_W | Byte address of the entry |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 64 | Entry returned |
| done | output | 1 | Walk finished (one cycle) |
| res_ok | output | 1 | 1 = translation, 0 = fault |
| res_spa | output | PA_W | Physical page base |
| res_shift | output | 7 | Page size shift |
| res_perm | output | 2 | {write, read} permissions |
| flt_code | output | 3 | 1 abort, 2 not present, 3 bad size, 4 bad level |
| flt_present | output | 1 | Present flag of the fault event |
| flt_addr | output | IOVA_W | Failing table address (code 1) or IOVA |
| flt_dev_id | output | ID_W | Device ID of the fault |
| flt_dom_id | output | ID_W | Domain ID of the fault |

## Verification
The bench targets the edges of the variable page-size window:
- A level-1 leaf whose bit 12 is clear must give shift 13. A design that counted the run of ones without the extra one would reject it.
- A level-2 size landing exactly on 30 must fault. A design using a non-strict upper bound would accept it.

A level-6 walk exercises the largest shift (57) and the rule that a variable-size leaf at level 6 is always rejected. Read errors and a missing present bit are checked so that the fault codes and the reported address (table address versus IOVA) cannot be swapped. A request arriving mid-walk must produce no extra read and no second completion.

// File: rtl/io_ptw_pkg.sv
package io_ptw_pkg;

    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned IDX_BITS   = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_READ,
        ST_WAIT_DATA,
        ST_DECODE,
        ST_DONE,
        ST_FAULT
    } ptw_state_e;

    typedef enum logic [2:0] {
        FLT_NONE        = 3'd0,
        FLT_HW_ABORT    = 3'd1,
        FLT_NOT_PRESENT = 3'd2,
        FLT_BAD_SIZE    = 3'd3,
        FLT_BAD_LEVEL   = 3'd4
    } ptw_fault_e;

    // Address bit where the index of a given level starts.
    function automatic logic [6:0] level_shift(input logic [2:0] lvl);
        int s;
        if (lvl == 3'd0) return 7'd0;
        s = int'(PAGE_SHIFT) + int'(IDX_BITS) * (int'(lvl) - 1);
        return 7'(s);
    endfunction

endpackage

// File: rtl/ptw_index_gen.sv
module ptw_index_gen
    import io_ptw_pkg::*;
#(
    parameter int unsigned IOVA_W = 64,
    parameter int unsigned PA_W   = 52
) (
    input  logic [IOVA_W-1:0] iova,
    input  logic [2:0]        lvl,
    input  logic [PA_W-1:0]   base,
    output logic [PA_W-1:0]   entry_addr
);
    localparam int unsigned ENTRY_BYTES_LOG2 = 3;

    logic [IOVA_W-1:0]   shifted;
    logic [IDX_BITS-1:0] idx;

    always_comb begin
        shifted    = iova >> level_shift(lvl);
        idx        = shifted[IDX_BITS-1:0];
        entry_addr = base + PA_W'({idx, {ENTRY_BYTES_LOG2{1'b0}}});
    end
endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import io_ptw_pkg::*;
#(
    parameter int unsigned PA_W = 52
) (
    input  logic [63:0]     entry,
    output logic            present,
    output logic [2:0]      next_lvl,
    output logic [PA_W-1:0] addr_field,
    output logic [1:0]      perm,
    output logic [6:0]      var_shift
);
    localparam int unsigned NEXT_LSB = 9;
    localparam int unsigned PERM_LSB = 61;

    logic found;

    always_comb begin
        present    = entry[0];
        next_lvl   = entry[NEXT_LSB +: 3];
        addr_field = {entry[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
        perm       = entry[PERM_LSB +: 2];
        // Run of ones from bit 12: size is one past the first zero.
        found     = 1'b0;
        var_shift = 7'(PA_W + 1);
        for (int i = PAGE_SHIFT; i < PA_W; i++) begin
            if (!found && !entry[i]) begin
                var_shift = 7'(i + 1);
                found     = 1'b1;
            end
        end
    end
endmodule

// File: rtl/io_pt_walker.sv
module io_pt_walker
    import io_ptw_pkg::*;
#(
    parameter int unsigned IOVA_W     = 64,
    parameter int unsigned PA_W       = 52,
    parameter int unsigned ID_W       = 16,
    parameter int unsigned MAX_LEVELS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [IOVA_W-1:0] req_iova,
    input  logic [PA_W-1:0]   req_root,
    input  logic [2:0]        req_levels,
    input  logic [ID_W-1:0]   req_dev_id,
    input  logic [ID_W-1:0]   req_dom_id,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [63:0]       mem_rsp_data,
    output logic              done,
    output logic              res_ok,
    output logic [PA_W-1:0]   res_spa,
    output logic [6:0]        res_shift,
    output logic [1:0]        res_perm,
    output logic [2:0]        flt_code,
    output logic              flt_present,
    output logic [IOVA_W-1:0] flt_addr,
    output logic [ID_W-1:0]   flt_dev_id,
    output logic [ID_W-1:0]   flt_dom_id
);
    localparam logic [2:0] TOP_LVL = 3'(MAX_LEVELS);

    ptw_state_e        state;
    logic [IOVA_W-1:0] iova_q;
    logic [PA_W-1:0]   base_q;
    logic [PA_W-1:0]   rd_addr_q;
    logic [2:0]        lvl_q;
    logic [ID_W-1:0]   dev_q, dom_q;
    logic [1:0]        perm_q;
    logic [63:0]       entry_q;
    logic [PA_W-1:0]   spa_q;
    logic [6:0]        shift_q;
    ptw_fault_e        code_q;
    logic              fpres_q;
    logic [IOVA_W-1:0] faddr_q;

    logic [PA_W-1:0] rd_addr;
    logic            e_present;
    logic [2:0]      e_next;
    logic [PA_W-1:0] e_addr;
    logic [1:0]      e_perm;
    logic [6:0]      e_vshift;
    logic            size_ok;

    ptw_index_gen #(.IOVA_W(IOVA_W), .PA_W(PA_W)) u_index (
        .iova(iova_q), .lvl(lvl_q), .base(base_q), .entry_addr(rd_addr)
    );

    ptw_entry_decode #(.PA_W(PA_W)) u_decode (
        .entry(entry_q), .present(e_present), .next_lvl(e_next),
        .addr_field(e_addr), .perm(e_perm), .var_shift(e_vshift)
    );

    always_comb begin
        size_ok = (lvl_q < TOP_LVL)
               && (e_vshift > level_shift(lvl_q))
               && (e_vshift < level_shift(3'(lvl_q + 3'd1)));
    end

    // State register and walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            iova_q    <= '0;
            base_q    <= '0;
            rd_addr_q <= '0;
            lvl_q     <= '0;
            dev_q     <= '0;
            dom_q     <= '0;
            perm_q    <= '0;
            entry_q   <= '0;
            spa_q     <= '0;
            shift_q   <= '0;
            code_q    <= FLT_NONE;
            fpres_q   <= 1'b0;
            faddr_q   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        iova_q  <= req_iova;
                        base_q  <= {req_root[PA_W-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
                        lvl_q   <= req_levels;
                        dev_q   <= req_dev_id;
                        dom_q   <= req_dom_id;
                        perm_q  <= 2'b11;
                        code_q  <= FLT_NONE;
                        fpres_q <= 1'b0;
                        faddr_q <= '0;
                        if (req_levels == 3'd0 || req_levels > TOP_LVL) begin
                            code_q  <= FLT_BAD_LEVEL;
                            fpres_q <= 1'b1;
                            faddr_q <= req_iova;
                            state   <= ST_FAULT;
                        end else begin
                            state <= ST_ISSUE_READ;
                        end
                    end
                end
                ST_ISSUE_READ: begin
                    rd_addr_q <= rd_addr;
                    state     <= ST_WAIT_DATA;
                end
                ST_WAIT_DATA: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            code_q  <= FLT_HW_ABORT;
                            fpres_q <= 1'b0;
                            faddr_q <= IOVA_W'(rd_addr_q);
                            state   <= ST_FAULT;
                        end else begin
                            entry_q <= mem_rsp_data;
                            state   <= ST_DECODE;
                        end
                    end
                end
                ST_DECODE: begin
                    if (!e_present) begin
                        code_q  <= FLT_NOT_PRESENT;
                        fpres_q <= 1'b0;
                        faddr_q <= iova_q;
                        state   <= ST_FAULT;
                    end else if (e_next == 3'd0) begin
                        spa_q   <= e_addr;
                        shift_q <= 7'(PAGE_SHIFT);
                        perm_q  <= perm_q & e_perm;
                        state   <= ST_DONE;
                    end else if (e_next == 3'd7) begin
                        if (size_ok) begin
                            spa_q   <= e_addr;
                            shift_q <= e_vshift;
                            perm_q  <= perm_q & e_perm;
                            state   <= ST_DONE;
                        end else begin
                            code_q  <= FLT_BAD_SIZE;
                            fpres_q <= 1'b1;
                            faddr_q <= iova_q;
                            state   <= ST_FAULT;
                        end
                    end else if (e_next >= lvl_q) begin
                        code_q  <= FLT_BAD_LEVEL;
                        fpres_q <= 1'b1;
                        faddr_q <= iova_q;
                        state   <= ST_FAULT;
                    end else begin
                        base_q <= e_addr;
                        lvl_q  <= e_next;
                        perm_q <= perm_q & e_perm;
                        state  <= ST_ISSUE_READ;
                    end
                end
                ST_DONE:  state <= ST_IDLE;
                ST_FAULT: state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_ISSUE_READ);
        mem_req_addr  = rd_addr;
        done          = (state == ST_DONE) || (state == ST_FAULT);
        res_ok        = (state == ST_DONE);
        res_spa       = spa_q;
        res_shift     = shift_q;
        res_perm      = perm_q;
        flt_code      = code_q;
        flt_present   = fpres_q;
        flt_addr      = faddr_q;
        flt_dev_id    = dev_q;
        flt_dom_id    = dom_q;
    end

    assert_one_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);
    assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_busy_not_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !req_ready);
    assert_fault_coded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !res_ok) |-> (flt_code != 3'd0));
    assert_shift_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && res_ok) |-> (res_shift >= 7'd12 && res_shift < 7'd57));
endmodule

// File: tb/io_pt_walker_tb_top.sv
module io_pt_walker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [63:0] req_iova = '0;
    logic [51:0] req_root = '0;
    logic [2:0]  req_levels = '0;
    logic [15:0] req_dev_id = '0, req_dom_id = '0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0, mem_rsp_err = 1'b0;
    logic [63:0] mem_rsp_data = '0;
    logic        done, res_ok, flt_present;
    logic [51:0] res_spa;
    logic [6:0]  res_shift;
    logic [1:0]  res_perm;
    logic [2:0]  flt_code;
    logic [63:0] flt_addr;
    logic [15:0] flt_dev_id, flt_dom_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    io_pt_walker dut_i (.*);

    typedef struct {
        bit          ok;
        logic [51:0] spa;
        logic [6:0]  shift;
        logic [1:0]  perm;
        logic [2:0]  code;
        bit          pres;
        logic [63:0] faddr;
        logic [15:0] dev, dom;
        string       tag;
    } exp_t;

    exp_t           exp_q[$];
    logic [51:0]    addr_q[$];
    string          addr_tag_q[$];
    logic [63:0]    mem[longint unsigned];
    bit             err_map[longint unsigned];
    int             checks = 0, fails = 0;
    bit             finished = 0;

    task automatic check(string req, bit cond, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [63:0] pte(logic [51:0] a, logic [2:0] nxt, logic [1:0] perm);
        return {1'b0, perm, 9'd0, a[51:12], nxt, 8'd0, 1'b1};
    endfunction

    // Memory model: checks each read address, answers two cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req_valid) begin
                automatic longint unsigned a = longint'(mem_req_addr);
                if (addr_q.size() == 0) begin
                    check("R11 unexpected read", 1'b0, mem_req_addr, 0);
                end else begin
                    automatic logic [51:0] ea = addr_q.pop_front();
                    automatic string t = addr_tag_q.pop_front();
                    check(t, mem_req_addr == ea, mem_req_addr, ea);
                end
                repeat (2) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_err   = err_map.exists(a);
                mem_rsp_data  = mem.exists(a) ? mem[a] : 64'd0;
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    // Monitor: compare every completion against the scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected done", 1'b0, 1, 0);
                end else begin
                    automatic exp_t e = exp_q.pop_front();
                    check(e.tag, res_ok == e.ok, res_ok, e.ok);
                    if (e.ok) begin
                        check(e.tag, res_spa == e.spa, res_spa, e.spa);
                        check(e.tag, res_shift == e.shift, res_shift, e.shift);
                        check({e.tag, " R10"}, res_perm == e.perm, res_perm, e.perm);
                    end else begin
                        check(e.tag, flt_code == e.code, flt_code, e.code);
                        check(e.tag, flt_present == e.pres, flt_present, e.pres);
                        check(e.tag, flt_addr == e.faddr, flt_addr, e.faddr);
                        check(e.tag, flt_dev_id == e.dev, flt_dev_id, e.dev);
                        check(e.tag, flt_dom_id == e.dom, flt_dom_id, e.dom);
                    end
                end
            end
        end
    end

    task automatic walk(logic [63:0] iova, logic [51:0] root, logic [2:0] lv, exp_t e, bit poke_busy);
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid  = 1'b1;
        req_iova   = iova;
        req_root   = root;
        req_levels = lv;
        req_dev_id = e.dev;
        req_dom_id = e.dom;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke_busy) begin
            check("R11 not ready while busy", req_ready == 1'b0, req_ready, 0);
            req_valid  = 1'b1;
            req_iova   = 64'hFFFF_FFFF;
            req_levels = 3'd1;
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    function automatic exp_t ok_e(logic [51:0] spa, logic [6:0] sh, logic [1:0] p, string tag);
        exp_t e;
        e = '{ok: 1, spa: spa, shift: sh, perm: p, code: 0, pres: 0, faddr: 0,
              dev: 16'h11, dom: 16'h22, tag: tag};
        return e;
    endfunction

    function automatic exp_t flt_e(logic [2:0] c, bit p, logic [63:0] fa, string tag);
        exp_t e;
        e = '{ok: 0, spa: 0, shift: 0, perm: 0, code: c, pres: p, faddr: fa,
              dev: 16'h5A5, dom: 16'h3C3, tag: tag};
        return e;
    endfunction

    function automatic void exp_rd(logic [51:0] a, string tag);
        addr_q.push_back(a);
        addr_tag_q.push_back(tag);
    endfunction

    initial begin
        // Page tables
        mem[64'h100028] = pte(52'h200000, 3'd2, 2'b11);
        mem[64'h200038] = pte(52'h300000, 3'd1, 2'b01);
        mem[64'h300048] = pte(52'hABCDE000, 3'd0, 2'b11);
        mem[64'h400018] = pte(52'h500000, 3'd1, 2'b11);
        err_map[64'h500020] = 1'b1;
        mem[64'h700008] = pte(52'h10FFF000, 3'd7, 2'b11);
        mem[64'h800010] = pte(52'h1000, 3'd7, 2'b11);
        mem[64'h900018] = pte(52'h40000000, 3'd7, 2'b10);
        mem[64'hA00020] = pte(52'h1FFFF000, 3'd7, 2'b11);
        mem[64'hA00028] = pte(52'h0FFFF000, 3'd7, 2'b11);
        mem[64'hB00028] = pte(52'hD00000, 3'd2, 2'b11);
        mem[64'hC00008] = pte(52'h0FFFF000, 3'd7, 2'b11);

        repeat (3) @(negedge clk);
        check("R1 done at reset", done == 1'b0, done, 0);
        check("R1 mem_req_valid at reset", mem_req_valid == 1'b0, mem_req_valid, 0);
        check("R1 req_ready at reset", req_ready == 1'b1, req_ready, 1);
        rst_n = 1'b1;

        // R2 R3 R5 R10: three-level walk to a 4K page, busy request ignored (R11)
        exp_rd(52'h100028, "R2 R3 level3 addr");
        exp_rd(52'h200038, "R2 level2 addr");
        exp_rd(52'h300048, "R2 level1 addr");
        walk((64'd5 << 30) | (64'd7 << 21) | (64'd9 << 12) | 64'h123, 52'h100000, 3'd3,
             ok_e(52'hABCDE000, 7'd12, 2'b01, "R5 4K leaf"), 1'b1);

        // R4: read error at second level
        exp_rd(52'h400018, "R2 abort walk l2");
        exp_rd(52'h500020, "R2 abort walk l1");
        walk((64'd3 << 21) | (64'd4 << 12), 52'h400000, 3'd2,
             flt_e(3'd1, 1'b0, 64'h500020, "R4 target abort"), 1'b0);

        // R8: entry not present
        exp_rd(52'h600010, "R2 np addr");
        walk(64'd2 << 12, 52'h600000, 3'd1,
             flt_e(3'd2, 1'b0, 64'd2 << 12, "R8 not present"), 1'b0);

        // R6: level-2 variable page, ones in bits 12..23 -> shift 25
        exp_rd(52'h700008, "R2 var addr");
        walk(64'd1 << 21, 52'h700000, 3'd2,
             ok_e(52'h10FFF000, 7'd25, 2'b11, "R6 var size 25"), 1'b0);

        // R7: level-2 size 14 too small
        exp_rd(52'h800010, "R2 small addr");
        walk(64'd2 << 21, 52'h800000, 3'd2,
             flt_e(3'd3, 1'b1, 64'd2 << 21, "R7 size below bound"), 1'b0);

        // R6 R7: level-1, bit 12 clear -> shift 13 accepted
        exp_rd(52'h900018, "R2 l1 var addr");
        walk(64'd3 << 12, 52'h900000, 3'd1,
             ok_e(52'h40000000, 7'd13, 2'b10, "R6 shift 13 at level 1"), 1'b0);

        // R7: shift exactly 30 at level 2 rejected, 29 accepted
        exp_rd(52'hA00020, "R2 up addr");
        walk(64'd4 << 21, 52'hA00000, 3'd2,
             flt_e(3'd3, 1'b1, 64'd4 << 21, "R7 shift 30 at upper bound"), 1'b0);
        exp_rd(52'hA00028, "R2 up2 addr");
        walk(64'd5 << 21, 52'hA00000, 3'd2,
             ok_e(52'h0FFFF000, 7'd29, 2'b11, "R7 shift 29 inside"), 1'b0);

        // R9: bad root levels, no read issued
        walk(64'h1000, 52'h100000, 3'd0,
             flt_e(3'd4, 1'b1, 64'h1000, "R9 root level 0"), 1'b0);
        walk(64'h2000, 52'h100000, 3'd7,
             flt_e(3'd4, 1'b1, 64'h2000, "R9 root level 7"), 1'b0);

        // R9: intermediate next level not below current
        exp_rd(52'hB00028, "R2 badlvl addr");
        walk(64'd5 << 21, 52'hB00000, 3'd2,
             flt_e(3'd4, 1'b1, 64'd5 << 21, "R9 next level not lower"), 1'b0);

        // R12 R3: level-6 variable leaf always faults; index from bit 57
        exp_rd(52'hC00008, "R3 level6 addr");
        walk(64'd1 << 57, 52'hC00000, 3'd6,
             flt_e(3'd3, 1'b1, 64'd1 << 57, "R12 var leaf at level 6"), 1'b0);

        check("R2 all reads consumed", addr_q.size() == 0, addr_q.size(), 0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule